// File: doc/BRIEF.md
# Strided 2D DMA Address Generator

This block produces the byte addresses for one side (read or write) of a two-dimensional strided copy. A descriptor is captured in the cycle `start` is high while the block is idle. It gives a 64-bit base address, two signed 32-bit steps, two 16-bit element counts and a 16-bit element size. The block then walks the grid with X as the inner loop and Y as the outer loop. It offers one address per element on a valid/ready pair. The descriptor is also checked when it is captured. A rejected descriptor produces no addresses. It raises `desc_err` together with the `done` pulse.

An optional upper-bound guard is configured by one control byte. Bits [5:0] name a limit register. The block exposes that register number on `lim_sel`, and the surrounding logic returns its value on `lim_val`. Bit 6 silences the out-of-range report, and bit 7 arms the guard. While the guard is armed, no address at or above the limit is ever offered. Hitting the limit ends the walk.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `addr_valid`, `done`, `desc_err` and `oob_err` are all 0.
- R2: The address for element (x, y) is base + x·step_x + y·step_y, computed modulo 2^64 with both steps sign-extended. x runs from 0 to num_x−1 fastest, and y runs from 0 to num_y−1 outer.
- R3: `addr` holds steady while `addr_valid` is high and `addr_ready` is low. Each accepted handshake advances exactly one element. A valid descriptor with no guard hit yields exactly num_x·num_y addresses.
- R4: `done` is a one-cycle pulse in the cycle after the last handshake. `busy` is 0 while `done` is high.
- R5: If num_x or num_y is 0, a valid descriptor yields no addresses and `done` rises one cycle after the start cycle.
- R6: The guard byte is accepted only when it is 8'h00, or when bit 7 is set and bits [5:0] are nonzero. Any other value, and the reserved kind 2'b11, is rejected. A rejection gives `desc_err`=1 and `done`=1 one cycle after start, and no addresses.
- R7: For kind 2'b00 (plain copy), a descriptor is rejected unless num_x·num_y·elem_size equals the 48-bit `peer_bytes` input.
- R8: For kind 2'b01 (transpose write side), a descriptor is rejected if base[4:0] ≠ 0. It is also rejected if a step's bits [4:0] are nonzero while that dimension's count is not 1. Kind 2'b10 applies only the R6 checks.
- R9: With the guard armed, an address ≥ `lim_val` is never offered. Reaching such an address ends the walk with `done`. `oob_err` rises with that `done` unless guard bit 6 is set. `lim_sel` shows guard bits [5:0] during the walk.
- R10: With the guard byte 8'h00, every address is emitted whatever the value of `lim_val`.
- R11: A `start` pulse while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the descriptor (honoured only when idle) |
| kind | input | 2 | 00 plain copy, 01 transpose write side, 10 unchecked, 11 reserved |
| start_addr | input | 64 | Base byte address |
| step_x | input | 32 | Signed inner-dimension byte step |
| step_y | input | 32 | Signed outer-dimension byte step |
| num_x | input | 16 | Inner element count |
| num_y | input | 16 | Outer element count |
| elem_size | input | 16 | Bytes per element |
| peer_bytes | input | 48 | Byte total of the opposite side, for the kind-00 match |
| bound_cfg | input | 8 | Guard byte: [7] arm, [6] silence, [5:0] limit register |
| lim_sel | output | 6 | Limit register number requested |
| lim_val | input | 64 | Value of the selected limit register |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | 64 | Current element byte address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-descriptor pulse |
| desc_err | output | 1 | Descriptor rejected (with done) |
| oob_err | output | 1 | Guard limit reached, not silenced (with done) |

## Verification
The hardest case to reach is the guard stopping a walk partway through. The stop must happen after some addresses have gone out, at an element that is not a row boundary, and with a consumer that stalls at random points. The bench reaches it by choosing `lim_val` equal to, or just above, a specific address in the middle of the grid. It drives the same grid armed, armed and silenced, and inert. For each case it derives from the formula which element must be the first one withheld. The sign-extension and 64-bit wrap paths are reached with bases near 2^32 and 2^64 and negative steps. A full sweep of small counts covers the zero-count and single-row edges.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    KIND_COPY  = 2'b00,
    KIND_XPOSE = 2'b01,
    KIND_FREE  = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  typedef struct packed {
    logic       arm;
    logic       quiet;
    logic [5:0] reg_no;
  } guard_t;
endpackage

// File: rtl/dma2d_desc_check.sv
module dma2d_desc_check #(
  parameter int AW = 64,
  parameter int SW = 32,
  parameter int CW = 16,
  parameter int ALIGN_LG2 = 5,
  localparam int TW = 3 * CW
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] step_x,
  input  logic [SW-1:0] step_y,
  input  logic [CW-1:0] num_x,
  input  logic [CW-1:0] num_y,
  input  logic [CW-1:0] elem_size,
  input  logic [TW-1:0] peer_bytes,
  input  dma2d_pkg::guard_t guard,
  output logic          bad
);
  import dma2d_pkg::*;

  logic          guard_ok;
  logic [TW-1:0] own_bytes;
  logic          copy_bad;
  logic          xpose_bad;

  always_comb begin
    guard_ok  = (guard == '0) || (guard.arm && (guard.reg_no != '0));
    own_bytes = TW'(num_x) * TW'(num_y) * TW'(elem_size);
    copy_bad  = (own_bytes != peer_bytes);
    xpose_bad = (start_addr[ALIGN_LG2-1:0] != '0)
             || ((step_x[ALIGN_LG2-1:0] != '0) && (num_x != CW'(1)))
             || ((step_y[ALIGN_LG2-1:0] != '0) && (num_y != CW'(1)));
    case (kind_e'(kind))
      KIND_COPY:  bad = !guard_ok || copy_bad;
      KIND_XPOSE: bad = !guard_ok || xpose_bad;
      KIND_FREE:  bad = !guard_ok;
      default:    bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dma2d_bound_cmp.sv
module dma2d_bound_cmp #(
  parameter int AW = 64
) (
  input  logic          armed,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] limit,
  output logic          hit
);
  always_comb hit = armed && (addr >= limit);
endmodule

// File: rtl/dma2d_step_walker.sv
module dma2d_step_walker #(
  parameter int AW = 64,
  parameter int SW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] step_x,
  input  logic [SW-1:0] step_y,
  input  logic [CW-1:0] num_x,
  input  logic [CW-1:0] num_y,
  output logic [AW-1:0] cur_addr,
  output logic          last
);
  logic [CW-1:0] x_q, x_d, y_q, y_d, nx_q, nx_d, ny_q, ny_d;
  logic [AW-1:0] row_q, row_d, cur_q, cur_d, sx_q, sx_d, sy_q, sy_d;
  logic          row_end;

  always_comb begin
    row_end = (x_q == nx_q - CW'(1));
    last    = row_end && (y_q == ny_q - CW'(1));
    x_d = x_q;  y_d = y_q;  nx_d = nx_q;  ny_d = ny_q;
    row_d = row_q;  cur_d = cur_q;  sx_d = sx_q;  sy_d = sy_q;
    if (load) begin
      x_d   = '0;
      y_d   = '0;
      nx_d  = num_x;
      ny_d  = num_y;
      sx_d  = {{(AW-SW){step_x[SW-1]}}, step_x};
      sy_d  = {{(AW-SW){step_y[SW-1]}}, step_y};
      row_d = start_addr;
      cur_d = start_addr;
    end else if (adv) begin
      if (row_end) begin
        x_d   = '0;
        y_d   = y_q + CW'(1);
        row_d = row_q + sy_q;
        cur_d = row_q + sy_q;
      end else begin
        x_d   = x_q + CW'(1);
        cur_d = cur_q + sx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;  y_q <= '0;  nx_q <= '0;  ny_q <= '0;
      row_q <= '0;  cur_q <= '0;  sx_q <= '0;  sy_q <= '0;
    end else if (load || adv) begin
      x_q <= x_d;  y_q <= y_d;  nx_q <= nx_d;  ny_q <= ny_d;
      row_q <= row_d;  cur_q <= cur_d;  sx_q <= sx_d;  sy_q <= sy_d;
    end
  end

  assign cur_addr = cur_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 64,
  parameter int SW = 32,
  parameter int CW = 16,
  parameter int ALIGN_LG2 = 5,
  localparam int TW = 3 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] step_x,
  input  logic [SW-1:0] step_y,
  input  logic [CW-1:0] num_x,
  input  logic [CW-1:0] num_y,
  input  logic [CW-1:0] elem_size,
  input  logic [TW-1:0] peer_bytes,
  input  logic [7:0]    bound_cfg,
  output logic [5:0]    lim_sel,
  input  logic [AW-1:0] lim_val,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          desc_err,
  output logic          oob_err
);
  import dma2d_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_e  state_q, state_d;
  guard_t  guard_q, guard_in;
  logic    done_q, done_d, derr_q, derr_d, oob_q, oob_d;
  logic    take, bad, zero, hit, adv, last, run, bc_armed;
  logic [AW-1:0] cur_addr;

  assign guard_in = guard_t'(bound_cfg);
  assign run      = (state_q == ST_RUN);
  assign take     = start && !run;
  assign zero     = (num_x == '0) || (num_y == '0);
  assign bc_armed = guard_q.arm;

  dma2d_desc_check #(.AW(AW), .SW(SW), .CW(CW), .ALIGN_LG2(ALIGN_LG2)) u_check (
    .kind(kind), .start_addr(start_addr), .step_x(step_x), .step_y(step_y),
    .num_x(num_x), .num_y(num_y), .elem_size(elem_size),
    .peer_bytes(peer_bytes), .guard(guard_in), .bad(bad)
  );

  dma2d_bound_cmp #(.AW(AW)) u_bound (
    .armed(bc_armed), .addr(cur_addr), .limit(lim_val), .hit(hit)
  );

  assign addr_valid = run && !hit;
  assign adv        = addr_valid && addr_ready;

  dma2d_step_walker #(.AW(AW), .SW(SW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_int_n), .load(take), .adv(adv),
    .start_addr(start_addr), .step_x(step_x), .step_y(step_y),
    .num_x(num_x), .num_y(num_y), .cur_addr(cur_addr), .last(last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    derr_d  = 1'b0;
    oob_d   = 1'b0;
    if (take) begin
      if (bad) begin
        done_d = 1'b1;
        derr_d = 1'b1;
      end else if (zero) begin
        done_d = 1'b1;
      end else begin
        state_d = ST_RUN;
      end
    end else if (run) begin
      if (hit) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        oob_d   = !guard_q.quiet;
      end else if (adv && last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      derr_q  <= 1'b0;
      oob_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      derr_q  <= derr_d;
      oob_q   <= oob_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  guard_q <= '0;
    else if (take)   guard_q <= guard_in;
  end

  assign lim_sel  = guard_q.reg_no;
  assign addr     = cur_addr;
  assign busy     = run;
  assign done     = done_q;
  assign desc_err = derr_q;
  assign oob_err  = oob_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          done,
  input logic          desc_err,
  input logic          oob_err,
  input logic          armed,
  input logic [AW-1:0] lim_val
);
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> busy); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> $stable(addr)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !addr_valid); // R4
  AST_REJECT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> done); // R6
  AST_OOB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    oob_err |-> done && !desc_err); // R9
  AST_NO_EMIT_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && armed |-> addr < lim_val); // R9
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr(addr), .busy(busy), .done(done), .desc_err(desc_err),
  .oob_err(oob_err), .armed(bc_armed), .lim_val(lim_val)
);

// File: tb/dma2d_addr_gen_test.sv
`timescale 1ns/1ps
module dma2d_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, addr_ready;
  logic [1:0]  kind;
  logic [63:0] start_addr, lim_val, addr;
  logic [31:0] step_x, step_y;
  logic [15:0] num_x, num_y, elem_size;
  logic [47:0] peer_bytes;
  logic [7:0]  bound_cfg;
  logic [5:0]  lim_sel;
  logic        addr_valid, busy, done, desc_err, oob_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma2d_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .start_addr(start_addr), .step_x(step_x), .step_y(step_y),
    .num_x(num_x), .num_y(num_y), .elem_size(elem_size),
    .peer_bytes(peer_bytes), .bound_cfg(bound_cfg), .lim_sel(lim_sel),
    .lim_val(lim_val), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .busy(busy), .done(done), .desc_err(desc_err),
    .oob_err(oob_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ea(input logic [63:0] s, input logic [31:0] sx,
                                     input logic [31:0] sy, input int x, input int y);
    logic signed [63:0] ex, ey;
    ex = 64'($signed(sx));
    ey = 64'($signed(sy));
    return s + 64'(ex * 64'(x)) + 64'(ey * 64'(y));
  endfunction

  task automatic run(input logic [1:0] k, input logic [63:0] sa,
                     input logic [31:0] sx, input logic [31:0] sy,
                     input logic [15:0] nx, input logic [15:0] ny,
                     input logic [15:0] es, input logic [47:0] pb,
                     input logic [7:0] bc, input logic [63:0] lim,
                     input int stall, input bit poke, input string req);
    bit bad, guard_ok, stopped, exp_oob, seen, sel_done;
    int n_exp, got, done_at;
    logic [47:0] own;
    guard_ok = (bc == 8'h00) || (bc[7] && bc[5:0] != 6'd0);
    own = 48'(nx) * 48'(ny) * 48'(es);
    bad = !guard_ok;
    if (k == 2'b00 && own != pb) bad = 1;
    if (k == 2'b01 && (sa[4:0] != 0 || (sx[4:0] != 0 && nx != 1) ||
                       (sy[4:0] != 0 && ny != 1))) bad = 1;
    if (k == 2'b11) bad = 1;
    n_exp = 0; stopped = 0;
    if (!bad) begin
      for (int y = 0; y < int'(ny) && !stopped; y++)
        for (int x = 0; x < int'(nx) && !stopped; x++)
          if (bc[7] && ea(sa, sx, sy, x, y) >= lim) stopped = 1;
          else n_exp++;
    end
    exp_oob = stopped && !bc[6];

    @(negedge clk);
    kind = k; start_addr = sa; step_x = sx; step_y = sy; num_x = nx; num_y = ny;
    elem_size = es; peer_bytes = pb; bound_cfg = bc; lim_val = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; seen = 0; done_at = -1; sel_done = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (poke && i == 1) begin start = 1'b1; start_addr = ~sa; num_x = 16'd1; end
      if (poke && i == 2) begin start = 1'b0; start_addr = sa; num_x = nx; end
      if (done) begin
        seen = 1; done_at = i;
      end else begin
        if (addr_valid) begin
          if (!sel_done) begin
            chk(lim_sel == bc[5:0], "R9", "lim_sel", 64'(lim_sel), 64'(bc[5:0]));
            sel_done = 1;
          end
          if (got < n_exp)
            chk(addr == ea(sa, sx, sy, got % int'(nx), got / int'(nx)), req,
                "address", addr, ea(sa, sx, sy, got % int'(nx), got / int'(nx)));
          else
            chk(0, "R3", "extra address", addr, 64'(n_exp));
          addr_ready = (stall == 0) || ((i % stall) != 0);
          if (addr_ready) got++;
        end else begin
          addr_ready = (i % 2) == 1;
        end
        @(negedge clk);
      end
    end
    chk(seen, "R4", "done seen", 64'(seen), 64'd1);
    chk(got == n_exp, req, "address count", 64'(got), 64'(n_exp));
    chk(desc_err == bad, req, "desc_err", 64'(desc_err), 64'(bad));
    chk(oob_err == exp_oob, "R9", "oob_err", 64'(oob_err), 64'(exp_oob));
    chk(!busy, "R4", "busy with done", 64'(busy), 64'd0);
    if (bad || nx == 0 || ny == 0)
      chk(done_at == 0, bad ? "R6" : "R5", "done latency", 64'(done_at), 64'd0);
    @(negedge clk);
    chk(!done, "R4", "done width", 64'(done), 64'd0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL R4 watchdog actual=%0d expected=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sxs[3];
    int sys[3];
    rst_n = 1'b0; start = 1'b0; addr_ready = 1'b0; kind = 2'b10;
    start_addr = '0; step_x = '0; step_y = '0; num_x = '0; num_y = '0;
    elem_size = '0; peer_bytes = '0; bound_cfg = '0; lim_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !addr_valid, "R1", "busy/valid", {62'd0, busy, addr_valid}, 64'd0);
    chk(!done && !desc_err && !oob_err, "R1", "done/errs",
        {61'd0, done, desc_err, oob_err}, 64'd0);

    // R2 R3 R5 sweep over small grids, inert guard
    sxs = '{1, -3, 64};
    sys = '{7, -100, 256};
    for (int nx = 0; nx < 4; nx++)
      for (int ny = 0; ny < 4; ny++)
        for (int s = 0; s < 3; s++)
          run(2'b10, 64'h0000_1000_0000_0400, 32'(sxs[s]), 32'(sys[s]),
              16'(nx), 16'(ny), 16'd2, 48'd0, 8'h00, 64'd0, s == 0 ? 0 : s + 1,
              0, (nx == 0 || ny == 0) ? "R5" : "R2");

    // R2 64-bit wrap and sign extension across 2^32
    run(2'b10, 64'hFFFF_FFFF_FFFF_FFF0, 32'd8, 32'd16, 16'd3, 16'd2, 16'd1,
        48'd0, 8'h00, 64'd0, 3, 0, "R2");
    run(2'b10, 64'h0000_0001_0000_0010, 32'hFFFF_FFF0, 32'h8000_0000, 16'd3,
        16'd2, 16'd1, 48'd0, 8'h00, 64'd0, 0, 0, "R2");
    // R11 start while busy ignored
    run(2'b10, 64'h2000, 32'd4, 32'd100, 16'd4, 16'd3, 16'd4, 48'd0, 8'h00,
        64'd0, 2, 1, "R11");
    // R7 plain copy byte match / mismatch
    run(2'b00, 64'h3000, 32'd2, 32'd40, 16'd5, 16'd3, 16'd2, 48'd30, 8'h00,
        64'd0, 0, 0, "R7");
    run(2'b00, 64'h3000, 32'd2, 32'd40, 16'd5, 16'd3, 16'd2, 48'd31, 8'h00,
        64'd0, 0, 0, "R7");
    // R8 transpose write-side alignment
    run(2'b01, 64'h4000, 32'd32, 32'd64, 16'd2, 16'd2, 16'd2, 48'd0, 8'h00,
        64'd0, 0, 0, "R8");
    run(2'b01, 64'h4010, 32'd32, 32'd64, 16'd2, 16'd2, 16'd2, 48'd0, 8'h00,
        64'd0, 0, 0, "R8");
    run(2'b01, 64'h4000, 32'd6, 32'd64, 16'd1, 16'd3, 16'd2, 48'd0, 8'h00,
        64'd0, 0, 0, "R8");
    run(2'b01, 64'h4000, 32'd6, 32'd64, 16'd2, 16'd3, 16'd2, 48'd0, 8'h00,
        64'd0, 0, 0, "R8");
    run(2'b01, 64'h4000, 32'd32, 32'd65, 16'd2, 16'd2, 16'd2, 48'd0, 8'h00,
        64'd0, 0, 0, "R8");
    // R6 guard byte validity and reserved kind
    run(2'b10, 64'h5000, 32'd1, 32'd8, 16'd2, 16'd2, 16'd1, 48'd0, 8'h40,
        64'hFFFF, 0, 0, "R6");
    run(2'b10, 64'h5000, 32'd1, 32'd8, 16'd2, 16'd2, 16'd1, 48'd0, 8'h80,
        64'hFFFF, 0, 0, "R6");
    run(2'b10, 64'h5000, 32'd1, 32'd8, 16'd2, 16'd2, 16'd1, 48'd0, 8'h07,
        64'hFFFF, 0, 0, "R6");
    run(2'b11, 64'h5000, 32'd1, 32'd8, 16'd2, 16'd2, 16'd1, 48'd0, 8'h00,
        64'hFFFF, 0, 0, "R6");
    // R9 armed guard stops mid-row, limit equal to an address
    run(2'b10, 64'h6000, 32'd4, 32'd64, 16'd4, 16'd3, 16'd4, 48'd0, 8'h85,
        64'h6048, 2, 0, "R9");
    run(2'b10, 64'h6000, 32'd4, 32'd64, 16'd4, 16'd3, 16'd4, 48'd0, 8'hC5,
        64'h6049, 3, 0, "R9");
    run(2'b10, 64'h6000, 32'd4, 32'd64, 16'd4, 16'd3, 16'd4, 48'd0, 8'hBF,
        64'h6000, 0, 0, "R9");
    run(2'b10, 64'h6000, 32'd4, 32'd64, 16'd4, 16'd3, 16'd4, 48'd0, 8'h85,
        64'h7000, 0, 0, "R9");
    // R10 inert guard ignores a tiny limit
    run(2'b10, 64'h6000, 32'd4, 32'd64, 16'd4, 16'd3, 16'd4, 48'd0, 8'h00,
        64'h0001, 2, 0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule